// File: doc/BRIEF.md
# Butterfly Lookup-Table Bit Network

This block transforms a 64-bit word through six cascaded butterfly stages. In stage k, every bit is paired with its partner: the bit whose index differs from its own only in bit k. The stage then produces each new bit from the current bit and its partner. The stages alternate between an and-or-invert gate (even stages) and an or-and-invert gate (odd stages). Each gate has two per-bit enables, one for the current bit and one for the partner. An 8-entry immediate table supplies those enables, and each stage picks its half of the table with its own bit of a 6-bit shift control. The operand can be inverted before the first stage, and the result can be inverted after the last stage. One gate layer per stage is enough to give bit reversal, swaps, inversions and many related permutations and combinations.

The network is combinational. It sits behind one output register with a valid/ready handshake on both sides. The rules for the handshake are as follows:
- An input is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty, or its word is being taken in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output word and `out_valid` stay unchanged and no new input is accepted.
- The parameter `OUT_REG = 0` removes the register. The handshake signals then pass straight through.

Top module: `bflut_net`

## Requirements
- R1: In stage k (k = 0..5), the partner of bit i is bit i XOR 2^k. With table 0x50 and shift control 0, the six stages reduce to a pure bit reversal (bit i moves to bit 63-i).
- R2: Stage k reads s = shift-control bit k. Call a bit position "low" when index bit k is 0, and "high" otherwise.
  - The keep enable takes table bit s at low positions and table bit s+2 at high positions.
  - The swap enable takes table bit s+4 at low positions and table bit s+6 at high positions.
- R3: Even stages (0, 2, 4) produce NOT((cur AND keep) OR (partner AND swap)).
- R4: Odd stages (1, 3, 5) produce (NOT cur AND keep) OR (NOT partner AND swap).
- R5: When `in_inv_pre` is 1, the operand is bitwise inverted before stage 0.
- R6: When `in_inv_post` is 1, the stage-5 result is bitwise inverted before it is output.
- R7: With an all-zero table, the result is all zeros whatever the operand, or all ones when `in_inv_post` is 1.
- R8: An accepted input appears on `out_result` with `out_valid` high after the next rising edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_result` and `out_valid` hold their values.
- R10: A synchronous active-high `rst` clears `out_valid` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_operand | input | 64 | Data word to transform |
| in_shamt | input | 6 | Shift control, one bit per stage |
| in_table | input | 8 | Immediate enable table |
| in_inv_pre | input | 1 | Invert operand before stage 0 |
| in_inv_post | input | 1 | Invert result after stage 5 |
| out_valid | output | 1 | Result word is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Transformed word |

## Verification
Directed vectors with hand-derived results isolate single features:
- Table 0x05 enables only the keep path, so six inversions give back the operand. This separates the keep path from the swap path and checks each invert flag on its own.
- Table 0x50 and table 0xA0 each enable only the swap path, under opposite shift-control values. They must produce a bit reversal, which proves the partner wiring of every stage and the selection of table bits by s.
- An all-zero table shows that the operand has no influence on the result.

A sweep of all 64 shift-control values uses operand 0x5555555555555555, table 0x52 and input inversion. Because each shift-control value selects a different table half in every stage, this sweep separates the per-stage selection. Random operands, tables and flags are then compared with a bit-level model. Short stall and reset sequences exercise the handshake.

// File: rtl/bflut_pkg.sv
package bflut_pkg;
  parameter int unsigned LOG2W   = 6;
  localparam int unsigned DATA_W  = 1 << LOG2W;
  localparam int unsigned TABLE_W = 8;

  typedef logic [DATA_W-1:0] word_t;

  // Positions whose index has bit k clear.
  function automatic word_t low_lanes(int unsigned k);
    word_t m;
    for (int unsigned i = 0; i < DATA_W; i++)
      m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction
endpackage

// File: rtl/bflut_enable.sv
module bflut_enable
  import bflut_pkg::*;
#(
  parameter int unsigned STAGE = 0
) (
  input  logic               sel,
  input  logic [TABLE_W-1:0] tbl,
  output word_t              keep_en,
  output word_t              swap_en
);
  localparam word_t LOW = low_lanes(STAGE);

  logic [2:0] base;
  logic       keep_lo, keep_hi, swap_lo, swap_hi;

  assign base    = {2'b00, sel};
  assign keep_lo = tbl[base];
  assign keep_hi = tbl[base + 3'd2];
  assign swap_lo = tbl[base + 3'd4];
  assign swap_hi = tbl[base + 3'd6];

  // R2: low lanes use the first entry, high lanes the entry two above
  assign keep_en = ({DATA_W{keep_lo}} & LOW) | ({DATA_W{keep_hi}} & ~LOW);
  assign swap_en = ({DATA_W{swap_lo}} & LOW) | ({DATA_W{swap_hi}} & ~LOW);
endmodule

// File: rtl/bflut_stage.sv
module bflut_stage
  import bflut_pkg::*;
#(
  parameter int unsigned STAGE = 0
) (
  input  word_t cur,
  input  word_t keep_en,
  input  word_t swap_en,
  output word_t nxt
);
  localparam int unsigned STEP = 1 << STAGE;

  word_t partner;

  // R1: butterfly wiring, index flipped in bit STAGE
  for (genvar i = 0; i < DATA_W; i++) begin : g_wire
    assign partner[i] = cur[i ^ STEP];
  end

  if (STAGE % 2 == 0) begin : g_aoi
    // R3
    assign nxt = ~((cur & keep_en) | (partner & swap_en));
  end else begin : g_oai
    // R4
    assign nxt = ~((cur | ~keep_en) & (partner | ~swap_en));
  end
endmodule

// File: rtl/bflut_core.sv
module bflut_core
  import bflut_pkg::*;
(
  input  word_t              operand,
  input  logic [LOG2W-1:0]   shamt,
  input  logic [TABLE_W-1:0] tbl,
  input  logic               inv_pre,
  input  logic               inv_post,
  output word_t              result
);
  word_t chain [LOG2W+1];

  // R5
  assign chain[0] = operand ^ {DATA_W{inv_pre}};

  for (genvar k = 0; k < LOG2W; k++) begin : g_stage
    word_t keep_en, swap_en;

    bflut_enable #(.STAGE(k)) u_en (
      .sel     (shamt[k]),
      .tbl     (tbl),
      .keep_en (keep_en),
      .swap_en (swap_en)
    );

    bflut_stage #(.STAGE(k)) u_st (
      .cur     (chain[k]),
      .keep_en (keep_en),
      .swap_en (swap_en),
      .nxt     (chain[k+1])
    );
  end

  // R6
  assign result = chain[LOG2W] ^ {DATA_W{inv_post}};
endmodule

// File: rtl/bflut_net.sv
module bflut_net
  import bflut_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_operand,
  input  logic [LOG2W-1:0]   in_shamt,
  input  logic [TABLE_W-1:0] in_table,
  input  logic               in_inv_pre,
  input  logic               in_inv_post,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_result
);
  word_t net_res;

  bflut_core u_core (
    .operand  (in_operand),
    .shamt    (in_shamt),
    .tbl      (in_table),
    .inv_pre  (in_inv_pre),
    .inv_post (in_inv_post),
    .result   (net_res)
  );

  if (OUT_REG) begin : g_reg
    logic  vld_q;
    word_t res_q;
    logic  take;

    assign in_ready   = !vld_q || out_ready;
    assign take       = in_valid && in_ready;
    assign out_valid  = vld_q;
    assign out_result = res_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
      end else if (take) begin
        vld_q <= 1'b1;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (take) res_q <= net_res;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid); // R10

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result))); // R9

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready); // R9

    AST_ZERO_TABLE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_table == '0)
        |=> out_result == {DATA_W{$past(in_inv_post)}}); // R7
  end else begin : g_comb
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_result = net_res;
  end
endmodule

// File: tb/bflut_net_bench.sv
module bflut_net_bench;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_operand = '0;
  logic [5:0]    in_shamt = '0;
  logic [7:0]    in_table = '0;
  logic          in_inv_pre = 1'b0;
  logic          in_inv_post = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bflut_net u_bflut_net (
    .clk, .rst, .in_valid, .in_ready, .in_operand, .in_shamt, .in_table,
    .in_inv_pre, .in_inv_post, .out_valid, .out_ready, .out_result
  );

  typedef struct packed {
    logic [W-1:0] op;
    logic [5:0]   sh;
    logic [7:0]   tab;
    logic         ii;
    logic         io;
    logic [W-1:0] exp;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{64'h0123456789ABCDEF, 6'h00, 8'h05, 1'b0, 1'b0, 64'h0123456789ABCDEF, 4'd3},  // R3 R4 keep path only
    '{64'h0123456789ABCDEF, 6'h00, 8'h05, 1'b1, 1'b0, 64'hFEDCBA9876543210, 4'd5},  // R5
    '{64'h0123456789ABCDEF, 6'h00, 8'h05, 1'b0, 1'b1, 64'hFEDCBA9876543210, 4'd6},  // R6
    '{64'h0123456789ABCDEF, 6'h3F, 8'h05, 1'b0, 1'b0, 64'h0,                4'd2},  // R2 s=1 picks empty half
    '{64'hDEADBEEFCAFEF00D, 6'h15, 8'h00, 1'b1, 1'b0, 64'h0,                4'd7},  // R7
    '{64'hDEADBEEFCAFEF00D, 6'h2A, 8'h00, 1'b0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 4'd7},  // R7
    '{64'h0000000000000001, 6'h00, 8'h50, 1'b0, 1'b0, 64'h8000000000000000, 4'd1},  // R1
    '{64'h00000000000000FF, 6'h00, 8'h50, 1'b0, 1'b0, 64'hFF00000000000000, 4'd1},  // R1
    '{64'h000000000000000F, 6'h3F, 8'hA0, 1'b0, 1'b0, 64'hF000000000000000, 4'd2}   // R2 s=1 upper entries
  };

  function automatic logic [W-1:0] model(logic [W-1:0] op, logic [5:0] sh,
                                         logic [7:0] tab, logic ii, logic io);
    logic [W-1:0] a, n;
    a = ii ? ~op : op;
    for (int k = 0; k < 6; k++) begin
      int s;
      s = sh[k] ? 1 : 0;
      for (int i = 0; i < W; i++) begin
        int  p;
        bit  hi, kb, sb;
        p  = i ^ (1 << k);
        hi = ((i >> k) & 1) == 1;
        kb = hi ? tab[s+2] : tab[s];
        sb = hi ? tab[s+6] : tab[s+4];
        if (k % 2 == 0) n[i] = !((a[i] && kb) || (a[p] && sb));
        else            n[i] = (!a[i] && kb) || (!a[p] && sb);
      end
      a = n;
    end
    return io ? ~a : a;
  endfunction

  task automatic check(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] op, logic [5:0] sh, logic [7:0] tab,
                     logic ii, logic io, logic [W-1:0] exp, string req);
    @(negedge clk);
    in_operand = op; in_shamt = sh; in_table = tab;
    in_inv_pre = ii; in_inv_post = io; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == exp, req, "result", out_result, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] a_val, b_val;
    repeat (3) @(negedge clk);
    check(!out_valid, "R10", "valid in reset", {63'b0, out_valid}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R10", "idle after reset", {63'b0, out_valid}, 64'h0);

    for (int v = 0; v < NV; v++)
      run(VECS[v].op, VECS[v].sh, VECS[v].tab, VECS[v].ii, VECS[v].io, VECS[v].exp,
          $sformatf("R%0d", VECS[v].req));

    // R2 R3 R4: sweep every shift control
    for (int s = 0; s < 64; s++)
      run(64'h5555555555555555, 6'(s), 8'b01010010, 1'b1, 1'b0,
          model(64'h5555555555555555, 6'(s), 8'b01010010, 1'b1, 1'b0), "R2");

    // R1..R6 random
    for (int r = 0; r < 300; r++) begin
      logic [W-1:0] op;
      logic [5:0]   sh;
      logic [7:0]   tb;
      logic         ii, io;
      op = {$urandom, $urandom};
      sh = 6'($urandom);
      tb = 8'($urandom);
      ii = 1'($urandom);
      io = 1'($urandom);
      run(op, sh, tb, ii, io, model(op, sh, tb, ii, io), "R4");
    end

    // R8 R9: stall holds output and blocks input
    a_val = model(64'h1122334455667788, 6'h09, 8'hC3, 1'b0, 1'b1);
    b_val = model(64'h8877665544332211, 6'h36, 8'h3C, 1'b1, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    in_operand = 64'h1122334455667788; in_shamt = 6'h09; in_table = 8'hC3;
    in_inv_pre = 1'b0; in_inv_post = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && out_result == a_val, "R8", "first word", out_result, a_val);
    in_operand = 64'h8877665544332211; in_shamt = 6'h36; in_table = 8'h3C;
    in_inv_pre = 1'b1; in_inv_post = 1'b0;
    check(!in_ready, "R9", "ready low in stall", {63'b0, in_ready}, 64'h0);
    @(negedge clk);
    check(out_valid && out_result == a_val, "R9", "held word", out_result, a_val);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == b_val, "R8", "second word", out_result, b_val);
    @(negedge clk);
    check(!out_valid, "R8", "drained", {63'b0, out_valid}, 64'h0);

    // R10: reset while holding a word
    run(64'hFFFF0000FFFF0000, 6'h00, 8'h05, 1'b0, 1'b0, 64'hFFFF0000FFFF0000, "R3");
    out_ready = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid, "R10", "reset clears", {63'b0, out_valid}, 64'h0);
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R10", "stays empty", {63'b0, out_valid}, 64'h0);

    finish_run();
  end
endmodule